// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a power-of-two ring of 8-byte transmit descriptors held in shared memory and turns every descriptor that the host has handed over into an outgoing frame. Each time the surrounding register file reports a write (a one-cycle trigger), the block makes one scan pass over the ring. For every qualifying descriptor it decodes the stored length, reads the matching fixed-size buffer byte by byte, streams the bytes out on a valid/ready frame port, and then writes the descriptor's flag byte back so that the host owns it again.

The block reaches memory through one simple byte-wide port with a fixed read latency of one cycle. A transmit-event strobe fires for every frame completed. One interrupt strobe fires at the end of a pass that sent at least one frame, if interrupts are enabled. While the stop input is high, triggers are discarded and memory is left untouched.

Top module: `txdesc_ring_reader`

## Requirements
- R1: Descriptor i sits at ring_base + 8*i. Its flag byte is at offset 2, and its length is at offsets 4 (high byte) and 5 (low byte). The buffer for descriptor i starts at buf_base + 64*i, and frame byte k is read from that start + k.
- R2: A descriptor is sent only when its flag byte equals exactly 0x83. Any other value (for example 0x82, 0x81, 0xC3 or 0x03) is left unchanged and produces no frame.
- R3: The byte count is the 16-bit two's-complement negation of the stored length. A count of zero emits no bytes, but the descriptor is still completed as in R5.
- R4: Frame bytes leave in buffer order on tx_valid/tx_ready. tx_last marks the final byte and tx_len carries the byte count. Data, last and length hold steady while a byte waits for tx_ready.
- R5: One cycle after the last byte is accepted, the value 0x03 is written to the flag byte. tint_o pulses for one cycle in that same cycle.
- R6: A pass starts at the saved ring index and visits the entries in increasing order modulo the ring size. It stops before the entry just below the start, so it covers ring size minus one entries.
- R7: The saved ring index advances by one for each frame sent. It does not jump to the entry after the one that was sent.
- R8: One pass may send several frames. irq_o pulses once, at the end of a pass, only if that pass sent a frame and irq_en_i is high.
- R9: A trigger that arrives or waits while stop_i is high is discarded. It causes no memory access and no frame, even after stop_i falls.
- R10: A trigger that arrives during a pass is held, and exactly one more pass starts once the current pass ends.
- R11: After reset, no output strobe or request is active and the saved ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | One-cycle scan trigger (a register write occurred) |
| stop_i | input | 1 | Stopped status; blocks scanning |
| irq_en_i | input | 1 | Interrupt enable status |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| buf_base_i | input | AW | Byte address of buffer 0 |
| mem_rd_o | output | 1 | Memory read request (data one cycle later) |
| mem_wr_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_rd_o |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_ready_i | input | 1 | Frame sink ready |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_len_o | output | LEN_W | Byte count of the current frame |
| tint_o | output | 1 | Pulse per completed frame |
| irq_o | output | 1 | End-of-pass interrupt pulse |

## Verification
A wrong saved ring index shows at the ports on the very next pass. The wrong descriptor's flag byte is read, and either a frame that should be excluded (the entry just below the start) goes out, or a ready entry is skipped, within a few hundred cycles of the trigger. A wrong decoded count shows at once as a wrong tx_len and a wrong number of bytes before tx_last. A lost or extra pending trigger shows as a missing or extra frame after the pass in progress ends. A pass-summary flag that is not cleared shows as an irq_o pulse after a pass that sent nothing.

// File: rtl/txr_pkg.sv
// Shared constants, state encoding and helpers for the transmit ring reader.
// Assumes 8-byte descriptors and byte-wide memory access.
package txr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CHK, ST_FLAG, ST_LEN0, ST_LEN1,
        ST_BREQ, ST_BDAT, ST_BOUT, ST_WB, ST_DONE
    } scan_st_e;

    localparam logic [7:0] FLAG_READY = 8'h83;  // owned + start + end
    localparam logic [7:0] FLAG_DONE  = 8'h03;  // returned to host
    localparam int DESC_LOG2  = 3;
    localparam int OFF_FLAG   = 2;
    localparam int OFF_LEN_HI = 4;
    localparam int OFF_LEN_LO = 5;
endpackage

// File: rtl/txr_len_decode.sv
// Turns the two stored length bytes into a byte count.
// Assumes the high byte is stored first and the value is a negated count.
module txr_len_decode #(
    parameter int LEN_W = 16
) (
    input  logic [7:0]       hi_i,
    input  logic [7:0]       lo_i,
    output logic [LEN_W-1:0] count_o
);
    logic [LEN_W-1:0] raw;

    // Assemble the stored value and negate it.
    always_comb begin
        raw     = LEN_W'({hi_i, lo_i});
        count_o = ~raw + LEN_W'(1);
    end
endmodule

// File: rtl/txr_ring_index.sv
// Keeps the saved ring index, the scan cursor and the pass end point.
// Assumes load_i and adv_i never coincide.
module txr_ring_index #(
    parameter int RING_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic                 adv_i,
    output logic [RING_LOG2-1:0] cur_o,
    output logic                 at_end_o
);
    localparam logic [RING_LOG2-1:0] ONE = RING_LOG2'(1);

    logic [RING_LOG2-1:0] saved_q, cur_q, stop_q;

    // Cursor load and step, saved-index advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
            cur_q   <= '0;
            stop_q  <= '0;
        end else begin
            if (load_i) begin
                cur_q  <= saved_q;
                stop_q <= saved_q - ONE;
            end else if (step_i) begin
                cur_q <= cur_q + ONE;
            end
            if (adv_i) saved_q <= saved_q + ONE;
        end
    end

    assign cur_o    = cur_q;
    assign at_end_o = (cur_q == stop_q);
endmodule

// File: rtl/txr_scan_ctrl.sv
// Sequencer for one scan pass: reads flag and length, streams the buffer,
// writes the flag back, and reports the end of the pass.
// Assumes memory read data arrives exactly one cycle after a read request.
module txr_scan_ctrl
    import txr_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RING_LOG2 = 2,
    parameter int BUF_LOG2  = 6,
    parameter int LEN_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 at_end_i,
    input  logic [RING_LOG2-1:0] cur_i,
    input  logic [AW-1:0]        ring_base_i,
    input  logic [AW-1:0]        buf_base_i,
    input  logic                 irq_en_i,
    output logic                 busy_o,
    output logic                 step_o,
    output logic                 adv_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic [AW-1:0]        mem_addr_o,
    output logic [7:0]           mem_wdata_o,
    input  logic [7:0]           mem_rdata_i,
    output logic                 tx_valid_o,
    input  logic                 tx_ready_i,
    output logic [7:0]           tx_data_o,
    output logic                 tx_last_o,
    output logic [LEN_W-1:0]     tx_len_o,
    output logic                 tint_o,
    output logic                 irq_o
);
    scan_st_e         st_q, st_d;
    logic [LEN_W-1:0] cnt_q, pos_q, dec_cnt;
    logic [7:0]       hi_q, byte_q;
    logic             sent_q;
    logic [AW-1:0]    desc_a, bufs_a;
    logic             flag_ok, at_last;

    txr_len_decode #(.LEN_W(LEN_W)) len_i (
        .hi_i(hi_q), .lo_i(mem_rdata_i), .count_o(dec_cnt)
    );

    // Base addresses of the current descriptor and its buffer.
    always_comb begin
        desc_a = ring_base_i + AW'({cur_i, {DESC_LOG2{1'b0}}});
        bufs_a = buf_base_i + AW'({cur_i, {BUF_LOG2{1'b0}}});
    end

    assign flag_ok = (mem_rdata_i == FLAG_READY);
    assign at_last = (pos_q == cnt_q - LEN_W'(1));

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (go_i) st_d = ST_CHK;
            ST_CHK:  st_d = at_end_i ? ST_DONE : ST_FLAG;
            ST_FLAG: st_d = flag_ok ? ST_LEN0 : ST_CHK;
            ST_LEN0: st_d = ST_LEN1;
            ST_LEN1: st_d = (dec_cnt == '0) ? ST_WB : ST_BREQ;
            ST_BREQ: st_d = ST_BDAT;
            ST_BDAT: st_d = ST_BOUT;
            ST_BOUT: if (tx_ready_i) st_d = at_last ? ST_WB : ST_BREQ;
            ST_WB:   st_d = ST_CHK;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counters, captured bytes and pass summary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pos_q  <= '0;
            hi_q   <= '0;
            byte_q <= '0;
            sent_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && go_i) sent_q <= 1'b0;
            if (st_q == ST_WB) sent_q <= 1'b1;
            if (st_q == ST_LEN0) hi_q <= mem_rdata_i;
            if (st_q == ST_LEN1) begin
                cnt_q <= dec_cnt;
                pos_q <= '0;
            end
            if (st_q == ST_BDAT) byte_q <= mem_rdata_i;
            if (st_q == ST_BOUT && tx_ready_i && !at_last) pos_q <= pos_q + LEN_W'(1);
        end
    end

    // Memory request decode and address selection.
    always_comb begin
        mem_rd_o   = 1'b0;
        mem_addr_o = desc_a + AW'(OFF_FLAG);
        unique case (st_q)
            ST_CHK:  mem_rd_o = !at_end_i;
            ST_FLAG: begin
                mem_rd_o   = flag_ok;
                mem_addr_o = desc_a + AW'(OFF_LEN_HI);
            end
            ST_LEN0: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = desc_a + AW'(OFF_LEN_LO);
            end
            ST_BREQ: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = bufs_a + AW'(pos_q);
            end
            default: ;
        endcase
    end

    assign mem_wr_o    = (st_q == ST_WB);
    assign mem_wdata_o = FLAG_DONE;
    assign tx_valid_o  = (st_q == ST_BOUT);
    assign tx_data_o   = byte_q;
    assign tx_last_o   = (st_q == ST_BOUT) && at_last;
    assign tx_len_o    = cnt_q;
    assign step_o      = (st_q == ST_FLAG && !flag_ok) || (st_q == ST_WB);
    assign adv_o       = (st_q == ST_WB);
    assign tint_o      = (st_q == ST_WB);
    assign irq_o       = (st_q == ST_DONE) && sent_q && irq_en_i;
    assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/txdesc_ring_reader.sv
// Top of the transmit descriptor ring reader. Holds the trigger latch and
// wires the ring index to the pass sequencer.
// Assumes RING_LOG2 >= 1 and that the address width covers ring and buffers.
module txdesc_ring_reader #(
    parameter int AW        = 16,
    parameter int RING_LOG2 = 2,
    parameter int BUF_LOG2  = 6,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             stop_i,
    input  logic             irq_en_i,
    input  logic [AW-1:0]    ring_base_i,
    input  logic [AW-1:0]    buf_base_i,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [7:0]       mem_wdata_o,
    input  logic [7:0]       mem_rdata_i,
    output logic             tx_valid_o,
    input  logic             tx_ready_i,
    output logic [7:0]       tx_data_o,
    output logic             tx_last_o,
    output logic [LEN_W-1:0] tx_len_o,
    output logic             tint_o,
    output logic             irq_o
);
    logic                 pend_q, busy, start, step, adv, at_end;
    logic [RING_LOG2-1:0] cur;

    assign start = !busy && pend_q && !stop_i;

    // Trigger latch: held across a pass, dropped while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (!busy && stop_i)  pend_q <= 1'b0;
        else if (start)            pend_q <= 1'b0;
        else if (kick_i)           pend_q <= 1'b1;
    end

    txr_ring_index #(.RING_LOG2(RING_LOG2)) idx_i (
        .clk(clk), .rst_n(rst_n), .load_i(start), .step_i(step),
        .adv_i(adv), .cur_o(cur), .at_end_o(at_end)
    );

    txr_scan_ctrl #(
        .AW(AW), .RING_LOG2(RING_LOG2), .BUF_LOG2(BUF_LOG2), .LEN_W(LEN_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .go_i(start), .at_end_i(at_end),
        .cur_i(cur), .ring_base_i(ring_base_i), .buf_base_i(buf_base_i),
        .irq_en_i(irq_en_i), .busy_o(busy), .step_o(step), .adv_o(adv),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .tx_data_o(tx_data_o), .tx_last_o(tx_last_o), .tx_len_o(tx_len_o),
        .tint_o(tint_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/txr_checker.sv
// Port-level protocol checks for the transmit ring reader, bound to the top.
module txr_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_en_i,
    input logic             mem_rd_o,
    input logic             mem_wr_o,
    input logic [7:0]       mem_wdata_o,
    input logic             tx_valid_o,
    input logic             tx_ready_i,
    input logic [7:0]       tx_data_o,
    input logic             tx_last_o,
    input logic [LEN_W-1:0] tx_len_o,
    input logic             irq_o
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
                                      && $stable(tx_last_o) && $stable(tx_len_o));

    assert_last_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last_o |-> tx_valid_o);

    assert_wb_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> mem_wdata_o == 8'h03);

    assert_wb_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_ready_i && tx_last_o |=> mem_wr_o);

    assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, tx_valid_o}));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

bind txdesc_ring_reader txr_checker #(.LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_en_i(irq_en_i), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
    .tx_len_o(tx_len_o), .irq_o(irq_o)
);

// File: tb/txdesc_ring_reader_tb_top.sv
module txdesc_ring_reader_tb_top;
    localparam int AW = 16, RL = 2, BL = 6, LW = 16;
    localparam int RING = 4, BUFB = 64, BUF0 = 256;

    // {flag byte, byte count, expect sent}
    localparam logic [31:0] VEC [0:6] = '{
        {8'h83, 16'd5,  8'd1}, {8'h82, 16'd4, 8'd0}, {8'h81, 16'd3, 8'd0},
        {8'hC3, 16'd3,  8'd0}, {8'h83, 16'd1, 8'd1}, {8'h03, 16'd2, 8'd0},
        {8'h83, 16'd64, 8'd1}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, kick = 1'b0, stop = 1'b0, irq_en = 1'b1, tx_ready = 1'b1;
    logic mem_rd, mem_wr, tx_valid, tx_last, tint, irq;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, tx_data;
    logic [LW-1:0] tx_len;

    logic [7:0] mem [0:1023];
    logic [7:0] cap [0:255];
    int cap_n, frames, last_len, n_tint, n_irq, n_rd, cyc, total, bad, idx;
    bit bp;

    txdesc_ring_reader #(.AW(AW), .RING_LOG2(RL), .BUF_LOG2(BL), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .stop_i(stop), .irq_en_i(irq_en),
        .ring_base_i(16'h0000), .buf_base_i(16'h0100),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
        .tx_last_o(tx_last), .tx_len_o(tx_len), .tint_o(tint), .irq_o(irq)
    );

    // Memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
    end

    // Sink and event monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        tx_ready = bp ? (cyc % 3 != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
            cap[cap_n[7:0]] = tx_data;
            cap_n++;
            if (tx_last) begin
                frames++;
                last_len = int'(tx_len);
            end
        end
        if (tint)   n_tint++;
        if (irq)    n_irq++;
        if (mem_rd) n_rd++;
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick_p();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic clr();
        cap_n = 0; frames = 0; last_len = -1; n_tint = 0; n_irq = 0; n_rd = 0;
    endtask

    task automatic set_entry(input int e, input logic [7:0] flag, input int cnt, input int seed);
        logic [15:0] neg;
        neg = 16'(-cnt);
        mem[e*8+2] = flag;
        mem[e*8+4] = neg[15:8];
        mem[e*8+5] = neg[7:0];
        for (int k = 0; k < BUFB; k++) mem[BUF0 + e*BUFB + k] = 8'(seed + k*3);
    endtask

    task automatic chk_data(input string tag, input int e, input int off, input int n);
        int mism;
        mism = 0;
        for (int k = 0; k < n; k++)
            if (cap[8'(off + k)] !== mem[BUF0 + e*BUFB + k]) mism++;
        chk(tag, mism, 0, "mismatching frame bytes");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
        clr();
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        // R11: quiet after reset
        chk("R11", int'(tx_valid), 0, "tx_valid after reset");
        chk("R11", n_irq + n_tint, 0, "strobes after reset");
        chk("R11", n_rd, 0, "reads after reset");

        // Table walk; the first vector targets entry 0 (R11 reset index).
        idx = 0;
        for (int v = 0; v < 7; v++) begin
            logic [7:0] fl;
            int cnt, e;
            fl = VEC[v][31:24];
            cnt = int'(VEC[v][23:8]);
            e = idx;
            clr();
            set_entry(e, fl, cnt, 16*v + 1);
            kick_p();
            wait_n(600);
            if (VEC[v][0]) begin
                chk("R2", frames, 1, "frames for ready flag");
                chk("R3", last_len, cnt, "decoded length");
                chk_data("R1", e, 0, cnt);
                chk("R5", int'(mem[e*8+2]), 3, "flag write-back");
                chk("R5", n_tint, 1, "tint pulses");
                chk("R8", n_irq, 1, "irq pulses");
                idx = (idx + 1) % RING;
            end else begin
                chk("R2", frames, 0, "frames for other flag");
                chk("R2", int'(mem[e*8+2]), int'(fl), "flag untouched");
                chk("R2", n_tint + n_irq, 0, "strobes for other flag");
            end
        end

        // R9: stop discards triggers
        clr();
        stop = 1'b1;
        set_entry(idx, 8'h83, 3, 90);
        kick_p();
        wait_n(100);
        chk("R9", frames, 0, "frames while stopped");
        chk("R9", n_rd, 0, "reads while stopped");
        chk("R9", int'(mem[idx*8+2]), 'h83, "flag while stopped");
        stop = 1'b0;
        wait_n(100);
        chk("R9", frames, 0, "trigger not kept after stop");
        kick_p();
        wait_n(600);
        chk("R9", frames, 1, "frame after fresh trigger");
        idx = (idx + 1) % RING;

        // R8: two frames in one pass, one interrupt
        clr();
        set_entry(idx, 8'h83, 2, 100);
        set_entry((idx + 1) % RING, 8'h83, 3, 110);
        kick_p();
        wait_n(600);
        chk("R8", frames, 2, "frames in one pass");
        chk("R8", n_tint, 2, "tint pulses");
        chk("R8", n_irq, 1, "irq pulses per pass");
        chk_data("R4", idx, 0, 2);
        chk_data("R4", (idx + 1) % RING, 2, 3);
        idx = (idx + 2) % RING;

        // R7 and R6: skip then send advances by one; entry below start excluded
        clr();
        mem[idx*8+2] = 8'h00;
        set_entry((idx + 1) % RING, 8'h83, 4, 120);
        kick_p();
        wait_n(600);
        chk("R7", frames, 1, "frame after skipped entry");
        clr();
        set_entry(idx, 8'h83, 2, 130);
        kick_p();
        wait_n(600);
        chk("R6", frames, 0, "entry below start not scanned");
        chk("R6", int'(mem[idx*8+2]), 'h83, "excluded flag untouched");
        mem[idx*8+2] = 8'h00;
        idx = (idx + 1) % RING;

        // R8: interrupt disabled
        clr();
        irq_en = 1'b0;
        set_entry(idx, 8'h83, 2, 140);
        kick_p();
        wait_n(600);
        chk("R8", frames, 1, "frame with irq disabled");
        chk("R8", n_irq, 0, "irq with enable low");
        chk("R5", n_tint, 1, "tint with enable low");
        irq_en = 1'b1;
        idx = (idx + 1) % RING;

        // R3: zero length
        clr();
        set_entry(idx, 8'h83, 0, 150);
        kick_p();
        wait_n(600);
        chk("R3", cap_n, 0, "bytes for zero length");
        chk("R3", int'(mem[idx*8+2]), 3, "zero length write-back");
        chk("R3", n_tint, 1, "zero length tint");
        idx = (idx + 1) % RING;

        // R4: backpressure
        clr();
        bp = 1'b1;
        set_entry(idx, 8'h83, 10, 160);
        kick_p();
        wait_n(600);
        bp = 1'b0;
        chk("R4", frames, 1, "frame under backpressure");
        chk("R4", cap_n, 10, "bytes under backpressure");
        chk_data("R4", idx, 0, 10);
        idx = (idx + 1) % RING;

        // R10: trigger during a pass starts one more pass
        clr();
        set_entry(idx, 8'h83, 40, 170);
        kick_p();
        wait_n(20);
        set_entry((idx + RING - 1) % RING, 8'h83, 3, 180);
        kick_p();
        wait_n(1500);
        chk("R10", frames, 2, "frames with held trigger");
        chk("R10", last_len, 3, "second pass frame length");
        chk_data("R10", idx, 0, 40);
        chk_data("R10", (idx + RING - 1) % RING, 40, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule